// File: doc/BRIEF.md
# Frame-Synchronized Shadow Register Bank

This block is the control register file of an imaging timing generator. A register port writes 28-bit words into a small address space, and a combinational read port returns any register. Some registers are immediate: their value drives the block's control outputs from the clock edge that completes the write. The remaining registers are frame-synchronized. A write lands in a shadow copy, and the active copy changes only at a programmable line of the vertical field.

The block synchronizes the vertical and horizontal sync inputs to its own clock and applies a programmable active polarity. It then detects the edges into the active level. Each vertical sync edge clears a line counter, and each horizontal sync edge advances it. When the count equals the programmed line, every shadow is copied to its active copy in one cycle, and this happens at most once per field. A suppress bit blocks the copy.

Writing the self-clearing reset bit returns the whole register space to its defaults. An output-enable control turns the gated outputs off at once. It turns them on only at the following vertical sync edge.

Top module: `fsr_regbank`

## Requirements
- R1: Every register is 28 bits wide, and all defaults are zero. Bits with no function read as 0. Writes to unused addresses (any address other than 0x00–0x02 and 0x10–0x13) are ignored, and those addresses read 0. The shadow read-back addresses 0x20–0x23 are read-only, so writes to them are ignored.
- R2: The system register at 0x00 is immediate, and its bits are laid out as follows. Bit 1 drives `core_run_o`, where 0 holds the timing core in reset and 1 lets it run. Bit 3 drives `bias_en_o`. Bit 2 selects the sync polarity. Both outputs follow from the cycle after the write.
- R3: A write to frame register 0x10+i updates only its shadow, which reads back at 0x20+i. The active copy reads back at 0x10+i and drives slice i of `frm_act_o`, and it keeps its value until a commit.
- R4: The update register at 0x01 holds the commit line in bits [12:0]. The line counter is cleared by each active vertical sync edge and incremented by each active horizontal sync edge. The copy happens once per field, when the count equals the line field. Later horizontal syncs in the same field cause no further copy.
- R5: If a frame register is written several times before a commit, only the last value is applied. All frame registers are committed in the same cycle.
- R6: Bit 13 of 0x01 suppresses the copy while it is 1. If the bit is cleared while the count still equals the line field and no copy has happened in this field, the pending copy takes place at once.
- R7: Writing 1 to bit 0 of 0x00 resets every register, shadow and active copy to its default and disables the outputs. Bit 0 then reads back as 0.
- R8: Bit 0 of 0x02 is the output enable. Writing 0 drives `out_en_o` low on the next cycle. After 1 is written, `out_en_o` goes high only at the next active vertical sync edge.
- R9: A polarity bit of 0 makes the sync inputs active low, and 1 makes them active high. Only a transition into the active level counts as an edge. Changing the polarity while an input rests at the new active level produces one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and sync clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 28 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 28 | Read data, combinational from rd_addr_i |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| out_en_o | output | 1 | Gated output enable |
| core_run_o | output | 1 | Timing core run (0 holds it in reset) |
| bias_en_o | output | 1 | Input bias enable |
| frm_act_o | output | 112 | Active frame registers, register i at bits [28i+27:28i] |

## Verification
The commit is tried with a sequence in which line 3 is programmed and horizontal syncs are counted one by one. This separates a copy at the correct count from a copy one line early or late. A horizontal sync after the copy shows whether the copy is limited to once per field. Overwrites made before the line and writes to two registers show whether the last value wins and the copy is simultaneous. A suppressed field followed by a release at the matching count separates a blocked copy from a lost one. The soft reset is issued with outputs enabled and pending data present, and an active-high pulse sequence confirms that the polarity bit chooses which level transition counts.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SYS_ADDR      = 'h00;
  localparam int UPD_ADDR      = 'h01;
  localparam int OUT_ADDR      = 'h02;
  localparam int FRM_ACT_BASE  = 'h10;
  localparam int FRM_SHD_BASE  = 'h20;

  localparam int SYS_SRST_BIT  = 0;
  localparam int SYS_RUN_BIT   = 1;
  localparam int SYS_POL_BIT   = 2;
  localparam int SYS_BIAS_BIT  = 3;
  localparam int OUT_EN_BIT    = 0;

  typedef struct packed {
    logic bias;
    logic pol;
    logic run;
  } sys_cfg_t;
endpackage

// File: rtl/fsr_sync_edge.sv
module fsr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic act_high_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              act;
  logic              act_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= raw_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], raw_i};
      end
    end
  endgenerate

  // polarity applied before edge detection
  assign act = act_high_i ? sync_q[STAGES-1] : !sync_q[STAGES-1];

  // reset value matches reset sync level under default polarity: no edge at start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b1;
    else         act_q <= act;
  end

  assign edge_o = act && !act_q;
endmodule

// File: rtl/fsr_line_ctr.sv
module fsr_line_ctr #(
  parameter int LINE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              vs_edge_i,
  input  logic              hs_edge_i,
  input  logic              suppress_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              commit_o
);
  logic [LINE_W-1:0] cnt_q;
  logic              done_q;

  assign commit_o = !done_q && !suppress_i && (cnt_q == line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (vs_edge_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (hs_edge_i && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
      if (commit_o)                   done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fsr_frame_bank.sv
module fsr_frame_bank #(
  parameter int N = 4,
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         commit_i,
  input  logic [N-1:0] wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [N*W-1:0] shadow_o,
  output logic [N*W-1:0] active_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_reg
      logic [W-1:0] shd_q;
      logic [W-1:0] act_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          shd_q <= '0;
          act_q <= '0;
        end else if (clear_i) begin
          shd_q <= '0;
          act_q <= '0;
        end else begin
          if (wr_sel_i[g]) shd_q <= wr_data_i;
          if (commit_i)    act_q <= shd_q;  // write in commit cycle stays pending
        end
      end

      assign shadow_o[g*W +: W] = shd_q;
      assign active_o[g*W +: W] = act_q;
    end
  endgenerate
endmodule

// File: rtl/fsr_regbank.sv
module fsr_regbank
  import fsr_pkg::*;
#(
  parameter int DATA_W      = 28,
  parameter int ADDR_W      = 8,
  parameter int LINE_W      = 13,
  parameter int N_FRM       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o,
  input  logic                    vsync_i,
  input  logic                    hsync_i,
  output logic                    out_en_o,
  output logic                    core_run_o,
  output logic                    bias_en_o,
  output logic [N_FRM*DATA_W-1:0] frm_act_o
);
  localparam int SUP_BIT = LINE_W;  // suppress sits just above the line field
  localparam int FRM_W   = N_FRM * DATA_W;

  logic wr_sys, wr_upd, wr_out, srst_wr;
  logic vs_edge, hs_edge, commit;

  sys_cfg_t          sys_q;
  logic [LINE_W-1:0] line_q;
  logic              sup_q;
  logic              outctl_q;
  logic              out_en_q;
  logic [N_FRM-1:0]  frm_sel;
  logic [FRM_W-1:0]  frm_shd;

  assign wr_sys  = wr_en_i && (wr_addr_i == ADDR_W'(SYS_ADDR));
  assign wr_upd  = wr_en_i && (wr_addr_i == ADDR_W'(UPD_ADDR));
  assign wr_out  = wr_en_i && (wr_addr_i == ADDR_W'(OUT_ADDR));
  assign srst_wr = wr_sys && wr_data_i[SYS_SRST_BIT];

  generate
    for (genvar i = 0; i < N_FRM; i++) begin : g_sel
      assign frm_sel[i] = wr_en_i && (wr_addr_i == ADDR_W'(FRM_ACT_BASE + i));
    end
  endgenerate

  // immediate registers; soft reset wins over the written value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q    <= '0;
      line_q   <= '0;
      sup_q    <= 1'b0;
      outctl_q <= 1'b0;
    end else if (srst_wr) begin
      sys_q    <= '0;
      line_q   <= '0;
      sup_q    <= 1'b0;
      outctl_q <= 1'b0;
    end else begin
      if (wr_sys) begin
        sys_q.run  <= wr_data_i[SYS_RUN_BIT];
        sys_q.pol  <= wr_data_i[SYS_POL_BIT];
        sys_q.bias <= wr_data_i[SYS_BIAS_BIT];
      end
      if (wr_upd) begin
        line_q <= wr_data_i[LINE_W-1:0];
        sup_q  <= wr_data_i[SUP_BIT];
      end
      if (wr_out) outctl_q <= wr_data_i[OUT_EN_BIT];
    end
  end

  // disable is immediate, enable waits for the next vertical sync edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        out_en_q <= 1'b0;
    else if (srst_wr || (wr_out && !wr_data_i[OUT_EN_BIT])) out_en_q <= 1'b0;
    else if (!outctl_q)                                 out_en_q <= 1'b0;
    else if (vs_edge)                                   out_en_q <= 1'b1;
  end

  fsr_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_i      (vsync_i),
    .act_high_i (sys_q.pol),
    .edge_o     (vs_edge)
  );

  fsr_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_i      (hsync_i),
    .act_high_i (sys_q.pol),
    .edge_o     (hs_edge)
  );

  fsr_line_ctr #(.LINE_W(LINE_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (srst_wr),
    .vs_edge_i  (vs_edge),
    .hs_edge_i  (hs_edge),
    .suppress_i (sup_q),
    .line_i     (line_q),
    .commit_o   (commit)
  );

  fsr_frame_bank #(.N(N_FRM), .W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (srst_wr),
    .commit_i  (commit),
    .wr_sel_i  (frm_sel),
    .wr_data_i (wr_data_i),
    .shadow_o  (frm_shd),
    .active_o  (frm_act_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(SYS_ADDR)) begin
      rd_data_o[SYS_RUN_BIT]  = sys_q.run;
      rd_data_o[SYS_POL_BIT]  = sys_q.pol;
      rd_data_o[SYS_BIAS_BIT] = sys_q.bias;
    end else if (rd_addr_i == ADDR_W'(UPD_ADDR)) begin
      rd_data_o[LINE_W-1:0] = line_q;
      rd_data_o[SUP_BIT]    = sup_q;
    end else if (rd_addr_i == ADDR_W'(OUT_ADDR)) begin
      rd_data_o[OUT_EN_BIT] = outctl_q;
    end
    for (int i = 0; i < N_FRM; i++) begin
      if (rd_addr_i == ADDR_W'(FRM_ACT_BASE + i)) rd_data_o = frm_act_o[i*DATA_W +: DATA_W];
      if (rd_addr_i == ADDR_W'(FRM_SHD_BASE + i)) rd_data_o = frm_shd[i*DATA_W +: DATA_W];
    end
  end

  assign out_en_o   = out_en_q;
  assign core_run_o = sys_q.run;
  assign bias_en_o  = sys_q.bias;
endmodule

// File: rtl/fsr_regbank_chk.sv
module fsr_regbank_chk #(
  parameter int W = 112,
  parameter int LINE_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              srst_wr_i,
  input logic              commit_i,
  input logic              vs_edge_i,
  input logic              suppress_i,
  input logic              out_en_i,
  input logic              oe_off_wr_i,
  input logic [W-1:0]      frm_act_i,
  input logic [LINE_W-1:0] line_i
);
  a_r3_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !srst_wr_i) |=> $stable(frm_act_i));

  a_r6_no_commit_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_i |-> !commit_i);

  a_r4_once_per_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !vs_edge_i) |=> !commit_i);

  a_r8_enable_at_vs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_i) |-> $past(vs_edge_i));

  a_r8_disable_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_off_wr_i |=> !out_en_i);

  a_r7_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_wr_i |=> (frm_act_i == '0 && line_i == '0 && !out_en_i));
endmodule

bind fsr_regbank fsr_regbank_chk #(
  .W      (N_FRM * DATA_W),
  .LINE_W (LINE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .srst_wr_i   (srst_wr),
  .commit_i    (commit),
  .vs_edge_i   (vs_edge),
  .suppress_i  (sup_q),
  .out_en_i    (out_en_o),
  .oe_off_wr_i (wr_out && !wr_data_i[fsr_pkg::OUT_EN_BIT]),
  .frm_act_i   (frm_act_o),
  .line_i      (line_q)
);

// File: tb/test_fsr_regbank.sv
module test_fsr_regbank;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [7:0]   wr_addr;
  logic [27:0]  wr_data;
  logic [7:0]   rd_addr;
  logic [27:0]  rd_data;
  logic         vsync, hsync;
  logic         out_en, core_run, bias_en;
  logic [111:0] frm_act;

  int  total = 0;
  int  bad   = 0;
  bit  pol_b = 1'b0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fsr_regbank i_fsr_regbank (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .vsync_i    (vsync),
    .hsync_i    (hsync),
    .out_en_o   (out_en),
    .core_run_o (core_run),
    .bias_en_o  (bias_en),
    .frm_act_o  (frm_act)
  );

  typedef enum logic [2:0] {OP_WR, OP_RD, OP_VS, OP_HS, OP_PINS} op_t;
  typedef struct packed {
    logic [3:0]  req;
    op_t         op;
    logic [7:0]  addr;
    logic [27:0] data;
    logic [27:0] expv;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{4'd1, OP_RD,   8'h00, 28'h0,       28'h0},        // R1 reset state
    '{4'd1, OP_WR,   8'h00, 28'hFFF000A, 28'h0},        // R1 R2 junk high bits
    '{4'd1, OP_RD,   8'h00, 28'h0,       28'h000000A},  // R1
    '{4'd2, OP_PINS, 8'h00, 28'h0,       28'h6},        // R2 bias, run on
    '{4'd1, OP_WR,   8'h05, 28'h1234567, 28'h0},        // R1 unused address
    '{4'd1, OP_RD,   8'h05, 28'h0,       28'h0},        // R1
    '{4'd4, OP_WR,   8'h01, 28'h0000003, 28'h0},        // R4 line 3
    '{4'd4, OP_RD,   8'h01, 28'h0,       28'h0000003},  // R4
    '{4'd5, OP_WR,   8'h10, 28'hABCDEF1, 28'h0},        // R5
    '{4'd5, OP_WR,   8'h11, 28'h1111111, 28'h0},        // R5
    '{4'd5, OP_WR,   8'h10, 28'h5A5A5A5, 28'h0},        // R5 overwrite
    '{4'd3, OP_RD,   8'h20, 28'h0,       28'h5A5A5A5},  // R3 shadow
    '{4'd3, OP_RD,   8'h21, 28'h0,       28'h1111111},  // R3
    '{4'd3, OP_RD,   8'h10, 28'h0,       28'h0},        // R3 active held
    '{4'd1, OP_WR,   8'h20, 28'h0000099, 28'h0},        // R1 read-only alias
    '{4'd1, OP_RD,   8'h20, 28'h0,       28'h5A5A5A5},  // R1
    '{4'd4, OP_VS,   8'h00, 28'h0,       28'h0},
    '{4'd4, OP_RD,   8'h10, 28'h0,       28'h0},        // R4 line 0: no copy
    '{4'd4, OP_HS,   8'h00, 28'h0,       28'h0},
    '{4'd4, OP_HS,   8'h00, 28'h0,       28'h0},
    '{4'd4, OP_RD,   8'h10, 28'h0,       28'h0},        // R4 line 2: no copy
    '{4'd4, OP_HS,   8'h00, 28'h0,       28'h0},
    '{4'd4, OP_RD,   8'h10, 28'h0,       28'h5A5A5A5},  // R4 R5 copy at line 3
    '{4'd5, OP_RD,   8'h11, 28'h0,       28'h1111111},  // R5 same cycle
    '{4'd4, OP_WR,   8'h10, 28'h0000077, 28'h0},
    '{4'd4, OP_HS,   8'h00, 28'h0,       28'h0},
    '{4'd4, OP_RD,   8'h10, 28'h0,       28'h5A5A5A5},  // R4 once per field
    '{4'd6, OP_WR,   8'h01, 28'h0002003, 28'h0},        // R6 suppress on
    '{4'd6, OP_VS,   8'h00, 28'h0,       28'h0},
    '{4'd6, OP_HS,   8'h00, 28'h0,       28'h0},
    '{4'd6, OP_HS,   8'h00, 28'h0,       28'h0},
    '{4'd6, OP_HS,   8'h00, 28'h0,       28'h0},
    '{4'd6, OP_RD,   8'h10, 28'h0,       28'h5A5A5A5},  // R6 blocked
    '{4'd6, OP_RD,   8'h01, 28'h0,       28'h0002003},  // R6
    '{4'd6, OP_WR,   8'h01, 28'h0000003, 28'h0},        // R6 release at line 3
    '{4'd6, OP_RD,   8'h10, 28'h0,       28'h0000077},  // R6 pending copy
    '{4'd8, OP_WR,   8'h02, 28'h0000001, 28'h0},
    '{4'd8, OP_PINS, 8'h00, 28'h0,       28'h6},        // R8 waits for vs
    '{4'd8, OP_VS,   8'h00, 28'h0,       28'h0},
    '{4'd8, OP_PINS, 8'h00, 28'h0,       28'h7},        // R8 enabled
    '{4'd8, OP_WR,   8'h02, 28'h0000000, 28'h0},
    '{4'd8, OP_PINS, 8'h00, 28'h0,       28'h6}         // R8 off at once
  };

  task automatic check(input int req, input logic [27:0] act, input logic [27:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [27:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input int req, input logic [7:0] a, input logic [27:0] expv);
    rd_addr = a;
    #1;
    check(req, rd_data, expv);
    @(negedge clk);
  endtask

  task automatic do_pins(input int req, input logic [2:0] expv);
    check(req, {25'd0, bias_en, core_run, out_en}, {25'd0, expv});
    @(negedge clk);
  endtask

  task automatic pulse_vs();
    vsync = pol_b;
    repeat (4) @(negedge clk);
    vsync = ~pol_b;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_hs();
    hsync = pol_b;
    repeat (4) @(negedge clk);
    hsync = ~pol_b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    vsync = 1'b1; hsync = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   do_write(VECS[i].addr, VECS[i].data);
        OP_RD:   do_read(int'(VECS[i].req), VECS[i].addr, VECS[i].expv);
        OP_VS:   pulse_vs();
        OP_HS:   pulse_hs();
        default: do_pins(int'(VECS[i].req), VECS[i].expv[2:0]);
      endcase
    end

    // R7: soft reset with outputs enabled and data pending
    do_write(8'h02, 28'h1);
    do_write(8'h10, 28'h0000123);
    pulse_vs();
    do_pins(8, 3'b111);                // R8 enabled again
    do_write(8'h00, 28'h000000B);      // reset bit with run, bias set
    do_read(7, 8'h00, 28'h0);          // R7 self-cleared, run dropped
    do_read(7, 8'h01, 28'h0);          // R7
    do_read(7, 8'h02, 28'h0);          // R7
    do_read(7, 8'h10, 28'h0);          // R7 active cleared
    do_read(7, 8'h20, 28'h0);          // R7 shadow cleared
    do_read(7, 8'h21, 28'h0);          // R7
    do_pins(7, 3'b000);                // R7 outputs off

    // R9: switch to active-high syncs; line field is 0 after reset
    do_write(8'h00, 28'h0000004);
    pol_b = 1'b1;
    vsync = 1'b0; hsync = 1'b0;
    repeat (4) @(negedge clk);
    do_read(9, 8'h00, 28'h0000004);    // R9 polarity readback
    do_write(8'h10, 28'h0000042);
    do_read(9, 8'h10, 28'h0);          // R9 no copy without a new edge
    pulse_vs();
    do_read(9, 8'h10, 28'h0000042);    // R9 high-going pulse commits at line 0

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule